// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the receive side of a three-wire control link (bus clock, identity strobe and an open-drain data line) for an audio processing chip. A controller frames each command with the identity line. It sends an 8-bit address byte while identity is low, raises identity, sends an 8-bit value byte, and then pulses identity low and high again to commit. The upper five bits of the address byte must equal the device match pattern `01000`. The lower three bits pick one of eight function registers, and the value byte is written into that register. All eight registers are presented side by side as parallel outputs for the analog circuitry.

Every bus line is brought into the system clock domain through two-flop synchronizers, and edges are found there. The system clock must therefore run at least eight times faster than the bus clock. A frame that is malformed or carries a foreign address is dropped without touching any register.

The block can also report two active-low status inputs to the controller. During a value phase aimed at function 7, the first two bit slots are status slots, and the block pulls the data line low in a slot whose status input is active. The controller releases the line in those slots, so the wired-AND result is what register 7 stores.

Top module: `ctl3w_slave`

## Requirements
- R1: After reset the registers hold: functions 0 and 1 (volume) 0x00, functions 2 and 3 (tone) 0x80, function 4 (control) 0x01 with mute in bit 0, and functions 5, 6 and 7 0x00.
- R2: Bits are sampled on the synchronized rising edge of the bus clock, least significant bit first. A frame has ID low for 8 address bits, then ID high for 8 value bits, then an ID low-high pulse. Such a frame with address 0x40+k writes the value byte into function register k.
- R3: When the upper five address bits are not `01000`, no register changes.
- R4: When ID rises after any number of address clocks other than 8, the frame is dropped and no register changes.
- R5: A register changes only on the rising ID edge that closes a frame with exactly 8 value clocks. Fewer or more value clocks leave every register unchanged.
- R6: In a value phase for function 7, value bit slot s (s = 0, 1) is pulled low while stat_n[s] is 0. The committed byte is the controller's byte ANDed with stat_n in bits 1:0.
- R7: data_pull is high only in the status slots of a function 7 value phase. At all other times the line is released, and the block never drives it high.
- R8: One committed frame changes at most one register, and the other seven keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock |
| bus_id | input | 1 | Identity strobe, low during the address phase |
| bus_data | input | 1 | Level observed on the open-drain data line |
| stat_n | input | 2 | Active-low status inputs reported through the data line |
| data_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| func_regs | output | 64 | Function registers, function k in bits 8k+7:8k |

## Verification
The assertions take for granted that a bus clock edge and an ID edge never fall within the same few system clock cycles. They also assume each bus level is held for several system clocks, and that the status inputs stay steady for the whole of a transfer. The stimulus keeps to this by holding each bus clock half period for 8 system cycles and by moving ID only while the bus clock is low and settled. It changes stat_n only between frames. A reference model that applies each frame three clocks after the closing ID rise is compared with the register outputs on every clock, and data_pull is checked just before each value-bit clock.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_VAL,
    ST_ARM
  } frame_st_e;

  // Power-up code for function register idx of width w.
  function automatic logic [31:0] rst_code(input int idx, input int w);
    case (idx)
      2, 3:    return 32'd1 << (w - 1);  // tone flat (mid-scale)
      4:       return 32'd1;             // control: mute set
      default: return 32'd0;             // volume minimum, others off
    endcase
  endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ctl3w_frame.sv
module ctl3w_frame
  import ctl3w_pkg::*;
#(
  parameter int                        DATA_W    = 8,
  parameter int                        FUNC_W    = 3,
  parameter int                        STAT_W    = 2,
  parameter logic [DATA_W-FUNC_W-1:0]  DEV_MATCH = 5'b01000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              bid_s,
  input  logic              bdat_s,
  input  logic [STAT_W-1:0] stat_s,
  output logic              commit,
  output logic [FUNC_W-1:0] commit_idx,
  output logic [DATA_W-1:0] commit_val,
  output logic              od_pull
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  frame_st_e         st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic [FUNC_W-1:0] fidx, fidx_n;
  logic              bclk_d, bid_d;
  logic              clk_rise, id_rise, id_fall;
  logic [DATA_W-1:0] shifted;

  assign clk_rise = bclk_s & ~bclk_d;
  assign id_rise  = bid_s & ~bid_d;
  assign id_fall  = ~bid_s & bid_d;
  assign shifted  = {bdat_s, sh[DATA_W-1:1]};

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    sh_n   = sh;
    fidx_n = fidx;
    commit = 1'b0;
    case (st)
      ST_IDLE: begin
        if (id_fall) begin
          st_n  = ST_ADDR;
          cnt_n = '0;
        end
      end
      ST_ADDR: begin
        if (id_rise) begin
          if (cnt == FULL && sh[DATA_W-1:FUNC_W] == DEV_MATCH) begin
            st_n   = ST_VAL;
            fidx_n = sh[FUNC_W-1:0];
            cnt_n  = '0;
          end else begin
            st_n = ST_IDLE;
          end
        end else if (clk_rise) begin
          if (cnt == FULL) begin
            st_n = ST_IDLE;
          end else begin
            sh_n  = shifted;
            cnt_n = cnt + CNT_W'(1);
          end
        end
      end
      ST_VAL: begin
        if (id_fall) begin
          if (cnt == FULL) begin
            st_n = ST_ARM;
          end else begin
            st_n  = ST_ADDR;
            cnt_n = '0;
          end
        end else if (clk_rise) begin
          if (cnt == FULL) begin
            st_n = ST_IDLE;
          end else begin
            sh_n  = shifted;
            cnt_n = cnt + CNT_W'(1);
          end
        end
      end
      ST_ARM: begin
        if (id_rise) begin
          commit = 1'b1;
          st_n   = ST_IDLE;
        end else if (clk_rise) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    od_pull = 1'b0;
    if (st == ST_VAL && fidx == {FUNC_W{1'b1}}) begin
      for (int k = 0; k < STAT_W; k++) begin
        if (cnt == CNT_W'(k) && !stat_s[k]) od_pull = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      fidx   <= '0;
      bclk_d <= 1'b0;
      bid_d  <= 1'b1;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      fidx   <= fidx_n;
      bclk_d <= bclk_s;
      bid_d  <= bid_s;
    end
  end

  assign commit_idx = fidx;
  assign commit_val = sh;

endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
  import ctl3w_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FUNC_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [FUNC_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]              wr_val,
  output logic [(DATA_W<<FUNC_W)-1:0]    regs_q
);

  localparam int NFUNC = 1 << FUNC_W;

  for (genvar k = 0; k < NFUNC; k++) begin : g_reg
    localparam logic [31:0] RV32 = rst_code(k, DATA_W);
    logic              hit;
    logic [DATA_W-1:0] q;

    assign hit = wr_en && (wr_idx == FUNC_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RV32[DATA_W-1:0];
      else if (hit) q <= wr_val;
    end

    assign regs_q[k*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
  import ctl3w_pkg::*;
#(
  parameter int                       DATA_W    = 8,
  parameter int                       FUNC_W    = 3,
  parameter int                       STAT_W    = 2,
  parameter int                       SYNC_N    = 2,
  parameter logic [DATA_W-FUNC_W-1:0] DEV_MATCH = 5'b01000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_clk,
  input  logic                        bus_id,
  input  logic                        bus_data,
  input  logic [STAT_W-1:0]           stat_n,
  output logic                        data_pull,
  output logic [(DATA_W<<FUNC_W)-1:0] func_regs
);

  localparam int SW = 3 + STAT_W;
  localparam logic [SW-1:0] SYNC_RST = {{STAT_W{1'b1}}, 1'b1, 1'b1, 1'b0};

  logic [SW-1:0]     sync_q;
  logic              clk_sync, id_sync, dat_sync;
  logic [STAT_W-1:0] stat_sync;
  logic              commit;
  logic [FUNC_W-1:0] commit_idx;
  logic [DATA_W-1:0] commit_val;

  ctl3w_sync #(.W(SW), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({stat_n, bus_data, bus_id, bus_clk}),
    .q     (sync_q)
  );

  assign clk_sync  = sync_q[0];
  assign id_sync   = sync_q[1];
  assign dat_sync  = sync_q[2];
  assign stat_sync = sync_q[SW-1:3];

  ctl3w_frame #(
    .DATA_W(DATA_W), .FUNC_W(FUNC_W), .STAT_W(STAT_W), .DEV_MATCH(DEV_MATCH)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_s     (clk_sync),
    .bid_s      (id_sync),
    .bdat_s     (dat_sync),
    .stat_s     (stat_sync),
    .commit     (commit),
    .commit_idx (commit_idx),
    .commit_val (commit_val),
    .od_pull    (data_pull)
  );

  ctl3w_regfile #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (commit),
    .wr_idx (commit_idx),
    .wr_val (commit_val),
    .regs_q (func_regs)
  );

endmodule

// File: rtl/ctl3w_slave_chk.sv
module ctl3w_slave_chk #(
  parameter int DATA_W = 8,
  parameter int FUNC_W = 3,
  parameter int STAT_W = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        data_pull,
  input logic                        id_sync,
  input logic [STAT_W-1:0]           stat_sync,
  input logic                        commit,
  input logic [(DATA_W<<FUNC_W)-1:0] func_regs
);

  localparam int NFUNC = 1 << FUNC_W;

  logic [(DATA_W<<FUNC_W)-1:0] prev;
  logic                        prev_ok;
  logic [NFUNC-1:0]            chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ok <= 1'b0;
    else        prev_ok <= 1'b1;
  end

  always_ff @(posedge clk) begin
    prev <= func_regs;
  end

  always_comb begin
    for (int k = 0; k < NFUNC; k++)
      chg[k] = prev_ok && (prev[k*DATA_W +: DATA_W] != func_regs[k*DATA_W +: DATA_W]);
  end

  AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1); // R8
  AST_CHANGE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> $past(commit)); // R5
  AST_COMMIT_ON_ID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (id_sync && !$past(id_sync))); // R2
  AST_PULL_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    data_pull |-> (stat_sync != {STAT_W{1'b1}})); // R6
  AST_PULL_ONLY_VALUE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    data_pull |-> id_sync); // R7

endmodule

bind ctl3w_slave ctl3w_slave_chk #(.DATA_W(DATA_W), .FUNC_W(FUNC_W), .STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .data_pull (data_pull),
  .id_sync   (id_sync),
  .stat_sync (stat_sync),
  .commit    (commit),
  .func_regs (func_regs)
);

// File: tb/ctl3w_slave_tb.sv
`timescale 1ns/1ps
module ctl3w_slave_tb;

  localparam int HB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_clk, bus_id, m_drv;
  logic [1:0]  stat_n;
  logic        data_pull;
  logic        bus_data;
  logic [63:0] func_regs;
  logic [63:0] exp_vec;
  int          compared = 0;
  int          mismatched = 0;
  int          cyc = 0;
  bit          running = 1'b0;
  string       cur_req = "R1";

  always #2.5 clk = ~clk;

  assign bus_data = m_drv & ~data_pull;

  ctl3w_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_clk   (bus_clk),
    .bus_id    (bus_id),
    .bus_data  (bus_data),
    .stat_n    (stat_n),
    .data_pull (data_pull),
    .func_regs (func_regs)
  );

  // every-clock comparison against the reference register image
  always @(negedge clk) begin
    if (running) begin
      compared++;
      if (func_regs !== exp_vec) begin
        mismatched++;
        $display("FAIL %s regs actual=%h expected=%h", cur_req, func_regs, exp_vec);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send_bit(input logic b, input logic exp_pull, input string req);
    m_drv = b;
    repeat (HB) @(negedge clk);
    compared++;
    if (data_pull !== exp_pull) begin
      mismatched++;
      $display("FAIL %s pull actual=%b expected=%b", req, data_pull, exp_pull);
    end
    bus_clk = 1'b1;
    repeat (HB) @(negedge clk);
    bus_clk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] v,
                      input int na, input int nv, input string req);
    bit   addr_ok;
    bit   apply;
    logic p;
    cur_req = req;
    addr_ok = (na == 8) && (a[7:3] == 5'b01000);
    apply   = addr_ok && (nv == 8);
    @(negedge clk);
    bus_id = 1'b0;
    repeat (HB) @(negedge clk);
    for (int i = 0; i < na; i++) send_bit(a[i % 8], 1'b0, req);
    repeat (HB) @(negedge clk);
    bus_id = 1'b1;
    repeat (HB) @(negedge clk);
    for (int i = 0; i < nv; i++) begin
      p = addr_ok && (a[2:0] == 3'd7) && (i < 2) && !stat_n[i % 2];
      send_bit(v[i % 8], p, (a[2:0] == 3'd7) ? "R6" : "R7");
    end
    m_drv = 1'b1;
    repeat (HB) @(negedge clk);
    bus_id = 1'b0;
    repeat (HB) @(negedge clk);
    bus_id = 1'b1;
    repeat (3) @(posedge clk);
    if (apply) begin
      if (a[2:0] == 3'd7) exp_vec[a[2:0]*8 +: 8] = v & {6'b111111, stat_n};
      else                exp_vec[a[2:0]*8 +: 8] = v;
    end
    repeat (4 * HB) @(negedge clk);
  endtask

  initial begin
    rst_n   = 1'b0;
    bus_clk = 1'b0;
    bus_id  = 1'b1;
    m_drv   = 1'b1;
    stat_n  = 2'b11;
    // R1 reset image: vol 00,00 tone 80,80 ctrl 01 others 00
    exp_vec = {8'h00, 8'h00, 8'h00, 8'h01, 8'h80, 8'h80, 8'h00, 8'h00};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (func_regs !== exp_vec) begin
      mismatched++;
      $display("FAIL R1 reset actual=%h expected=%h", func_regs, exp_vec);
    end
    running = 1'b1;
    repeat (10) @(negedge clk);

    // R2 / R8 normal writes
    xfer(8'h40, 8'h3C, 8, 8, "R2");
    xfer(8'h43, 8'hA5, 8, 8, "R2");
    xfer(8'h44, 8'h00, 8, 8, "R2");
    xfer(8'h41, 8'hFF, 8, 8, "R8");
    xfer(8'h46, 8'h5A, 8, 8, "R2");
    // R3 foreign addresses
    xfer(8'h48, 8'h11, 8, 8, "R3");
    xfer(8'h00, 8'h22, 8, 8, "R3");
    xfer(8'hC2, 8'h33, 8, 8, "R3");
    // R4 wrong address length
    xfer(8'h42, 8'h44, 7, 8, "R4");
    xfer(8'h42, 8'h55, 9, 8, "R4");
    // R5 wrong value length
    xfer(8'h45, 8'h66, 8, 7, "R5");
    xfer(8'h45, 8'h77, 8, 9, "R5");
    // R7 status active but write to another function: no pull
    stat_n = 2'b00;
    repeat (HB) @(negedge clk);
    xfer(8'h45, 8'h99, 8, 8, "R7");
    // R6 status readback into function 7
    stat_n = 2'b10;
    repeat (HB) @(negedge clk);
    xfer(8'h47, 8'hFF, 8, 8, "R6");
    stat_n = 2'b01;
    repeat (HB) @(negedge clk);
    xfer(8'h47, 8'hF3, 8, 8, "R6");
    stat_n = 2'b11;
    repeat (HB) @(negedge clk);
    xfer(8'h47, 8'hFF, 8, 8, "R6");
    xfer(8'h42, 8'h01, 8, 8, "R2");

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule